// File: doc/BRIEF.md
# Region Address Translation Unit

This block sits between a 32-bit bus master and a 48-bit system interconnect and rewrites each bus address through a table of sixteen software-programmed windows. Each window has a control word, a local base address and a 48-bit system base. The control word holds an enable flag and a log2 window size. When an enabled window covers an incoming address, the base is replaced and the offset inside the window is kept. The result is the wider system address.

Software programs the windows through a word-addressed register port. Reads return the word at the given offset in the same cycle. Translation requests arrive with a valid flag, and the answer appears one clock later on a registered response. The parameter `PASS_THRU` selects what happens to an address that no enabled window covers:

- With `PASS_THRU` = 1, the address is zero-extended to 48 bits.
- With `PASS_THRU` = 0, a miss flag is raised.

Top module: `addr_remap_unit`

## Requirements
- R1: There are 16 regions. Region n owns four 32-bit words starting at byte offset 0x20 + 0x10·n. The word at +0x0 is the control word, +0x4 is the local base, +0x8 is system base bits [31:0], and +0xC holds system base bits [47:32] in bits [15:0]; reading this word returns bits [31:16] as zero.
- R2: After reset every register reads zero and every region is disabled.
- R3: A read returns the last value written, with reserved bits as zero. Any offset outside the region blocks reads zero, and a write to it changes nothing. Offsets outside the blocks include those below 0x20, those at or above 0x120, and any offset with bits [1:0] not zero.
- R4: Control bit 31 enables the region and bits [5:0] hold the log2 window size in bytes; bits [30:6] read as zero. A size code above 32 spans the whole 32-bit local space.
- R5: An address A hits region n when A and the local base agree above the low `size` bits. The system address is the 48-bit system base with its low `size` bits replaced by those of A. The low `size` bits of both bases are ignored.
- R6: When several enabled regions hit, the lowest-numbered region supplies the translation.
- R7: With PASS_THRU = 1, an address no enabled region hits returns that address zero-extended to 48 bits, with the miss flag low.
- R8: With PASS_THRU = 0, an address no enabled region hits returns the miss flag high and an address of zero. The miss flag is only high together with the response valid flag.
- R9: A request sampled with reqValid high at a clock edge is answered at that same edge, so rspValid is high during the following cycle. rspValid is low in every cycle after an edge where reqValid was low.
- R10: A configuration write changes the translation of requests presented in the following cycle. A request presented in the same cycle as the write still uses the old setting.
- R11: Writing zero to a control word disables that region, so its window no longer hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 9 | Configuration byte offset |
| cfgWdata | input | 32 | Configuration write data |
| cfgRdata | output | 32 | Configuration read data for cfgAddr (combinational) |
| reqValid | input | 1 | Translation request valid |
| reqAddr | input | 32 | Local address to translate |
| rspValid | output | 1 | Response valid, one cycle after the request |
| rspAddr | output | 48 | Translated system address |
| rspMiss | output | 1 | No enabled region covered the request (miss-flag mode only) |

## Verification
The bench builds two copies of the block side by side on the same stimulus: one with `PASS_THRU` = 1 and one with `PASS_THRU` = 0. The other parameters keep their defaults: 16 regions, 32-bit local and 48-bit system addresses. Every uncovered address is therefore checked for zero-extension and for the miss flag with zero address in the same cycle.

The overlapping windows exercise the lowest-index priority. A size code of 63 tests the clamp to the full local space. A base with non-zero low bits shows that those bits are ignored. A write that coincides with a request shows the one-cycle update rule.

// File: rtl/remap_pkg.sv
package remap_pkg;

  // Word inside a region block, decoded from byte offset bits [3:2]
  typedef enum logic [1:0] {
    FLD_CTRL   = 2'd0,
    FLD_INBASE = 2'd1,
    FLD_OUTLO  = 2'd2,
    FLD_OUTHI  = 2'd3
  } fld_e;

  // Strobes from configuration decode to the datapath
  typedef struct packed {
    logic wrEn;
    logic rdEn;
    fld_e fld;
  } cfg_stb_t;

  localparam int CTRL_EN_BIT   = 31;
  localparam int SIZE_W        = 6;
  localparam int REGION_BASE   = 'h20;
  localparam int REGION_STRIDE = 'h10;

endpackage

// File: rtl/remap_ctrl.sv
module remap_ctrl
  import remap_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int CFG_AW      = 9,
  localparam int RIDX_W     = $clog2(NUM_REGIONS)
) (
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  output cfg_stb_t          stb,
  output logic [RIDX_W-1:0] region
);

  localparam int SPAN = REGION_STRIDE * NUM_REGIONS;

  logic [CFG_AW-1:0] off;
  logic              inMap;

  always_comb begin
    off   = cfgAddr - CFG_AW'(REGION_BASE);
    inMap = (cfgAddr >= CFG_AW'(REGION_BASE)) &&
            (off < CFG_AW'(SPAN)) &&
            (cfgAddr[1:0] == 2'b00);
    region   = off[4 +: RIDX_W];
    stb.fld  = fld_e'(off[3:2]);
    stb.rdEn = inMap;
    stb.wrEn = inMap && cfgWe;
  end

endmodule

// File: rtl/remap_slot.sv
module remap_slot
  import remap_pkg::*;
#(
  parameter int LOCAL_W = 32,
  parameter int SYS_W   = 48,
  localparam int HI_W   = SYS_W - LOCAL_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  fld_e               fld,
  input  logic [LOCAL_W-1:0] wdata,
  input  logic [LOCAL_W-1:0] lookAddr,
  output logic               hit,
  output logic [SYS_W-1:0]   xlatAddr,
  output logic [LOCAL_W-1:0] rdWord
);

  logic              enable;
  logic [SIZE_W-1:0] sizeCode;
  logic [LOCAL_W-1:0] inBase;
  logic [LOCAL_W-1:0] outLo;
  logic [HI_W-1:0]    outHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable   <= 1'b0;
      sizeCode <= '0;
      inBase   <= '0;
      outLo    <= '0;
      outHi    <= '0;
    end else if (wrEn) begin
      case (fld)
        FLD_CTRL: begin
          enable   <= wdata[CTRL_EN_BIT];
          sizeCode <= wdata[SIZE_W-1:0];
        end
        FLD_INBASE: inBase <= wdata;
        FLD_OUTLO:  outLo  <= wdata;
        default:    outHi  <= wdata[HI_W-1:0];
      endcase
    end
  end

  // Window mask: low sizeEff bits set; codes past LOCAL_W clamp to full space
  logic [SIZE_W-1:0]  sizeEff;
  logic [LOCAL_W:0]   onePos;
  logic [LOCAL_W-1:0] winMask;
  logic [SYS_W-1:0]   sysBase;
  logic [SYS_W-1:0]   sysMask;

  always_comb begin
    sizeEff  = (sizeCode > SIZE_W'(LOCAL_W)) ? SIZE_W'(LOCAL_W) : sizeCode;
    onePos   = {{LOCAL_W{1'b0}}, 1'b1} << sizeEff;
    winMask  = LOCAL_W'(onePos - {{LOCAL_W{1'b0}}, 1'b1});
    hit      = enable && (((lookAddr ^ inBase) & ~winMask) == '0);
    sysBase  = {outHi, outLo};
    sysMask  = SYS_W'(winMask);
    xlatAddr = (sysBase & ~sysMask) | (SYS_W'(lookAddr) & sysMask);
  end

  always_comb begin
    rdWord = '0;
    case (fld)
      FLD_CTRL: begin
        rdWord[CTRL_EN_BIT]  = enable;
        rdWord[SIZE_W-1:0]   = sizeCode;
      end
      FLD_INBASE: rdWord = inBase;
      FLD_OUTLO:  rdWord = outLo;
      default:    rdWord = LOCAL_W'(outHi);
    endcase
  end

endmodule

// File: rtl/remap_dpath.sv
module remap_dpath
  import remap_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int LOCAL_W     = 32,
  parameter int SYS_W       = 48,
  parameter bit PASS_THRU   = 1'b1,
  localparam int RIDX_W     = $clog2(NUM_REGIONS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfg_stb_t           stb,
  input  logic [RIDX_W-1:0]  region,
  input  logic [LOCAL_W-1:0] cfgWdata,
  output logic [LOCAL_W-1:0] cfgRdata,
  input  logic               reqValid,
  input  logic [LOCAL_W-1:0] reqAddr,
  output logic               rspValid,
  output logic [SYS_W-1:0]   rspAddr,
  output logic               rspMiss
);

  logic [NUM_REGIONS-1:0] hitVec;
  logic [SYS_W-1:0]       xlatArr [NUM_REGIONS];
  logic [LOCAL_W-1:0]     rdArr   [NUM_REGIONS];

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_slot
    remap_slot #(
      .LOCAL_W (LOCAL_W),
      .SYS_W   (SYS_W)
    ) u_slot (
      .clk      (clk),
      .rstN     (rstN),
      .wrEn     (stb.wrEn && (region == RIDX_W'(i))),
      .fld      (stb.fld),
      .wdata    (cfgWdata),
      .lookAddr (reqAddr),
      .hit      (hitVec[i]),
      .xlatAddr (xlatArr[i]),
      .rdWord   (rdArr[i])
    );
  end

  assign cfgRdata = stb.rdEn ? rdArr[region] : '0;

  // Lowest-numbered hit wins: scan downward so the lowest index is assigned last
  logic             anyHit;
  logic [SYS_W-1:0] hitAddr;

  always_comb begin
    anyHit  = |hitVec;
    hitAddr = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hitVec[i]) hitAddr = xlatArr[i];
    end
  end

  logic [SYS_W-1:0] missAddr;
  logic             missFlag;

  if (PASS_THRU) begin : g_pass
    assign missAddr = SYS_W'(reqAddr);
    assign missFlag = 1'b0;
  end else begin : g_flag
    assign missAddr = '0;
    assign missFlag = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspAddr  <= '0;
      rspMiss  <= 1'b0;
    end else begin
      rspValid <= reqValid;
      if (reqValid) begin
        rspAddr <= anyHit ? hitAddr : missAddr;
        rspMiss <= !anyHit && missFlag;
      end else begin
        rspMiss <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/addr_remap_unit.sv
module addr_remap_unit
  import remap_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int LOCAL_W     = 32,
  parameter int SYS_W       = 48,
  parameter int CFG_AW      = 9,
  parameter bit PASS_THRU   = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [CFG_AW-1:0]  cfgAddr,
  input  logic [LOCAL_W-1:0] cfgWdata,
  output logic [LOCAL_W-1:0] cfgRdata,
  input  logic               reqValid,
  input  logic [LOCAL_W-1:0] reqAddr,
  output logic               rspValid,
  output logic [SYS_W-1:0]   rspAddr,
  output logic               rspMiss
);

  localparam int RIDX_W = $clog2(NUM_REGIONS);

  cfg_stb_t          stb;
  logic [RIDX_W-1:0] region;

  remap_ctrl #(
    .NUM_REGIONS (NUM_REGIONS),
    .CFG_AW      (CFG_AW)
  ) u_ctrl (
    .cfgWe   (cfgWe),
    .cfgAddr (cfgAddr),
    .stb     (stb),
    .region  (region)
  );

  remap_dpath #(
    .NUM_REGIONS (NUM_REGIONS),
    .LOCAL_W     (LOCAL_W),
    .SYS_W       (SYS_W),
    .PASS_THRU   (PASS_THRU)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .region   (region),
    .cfgWdata (cfgWdata),
    .cfgRdata (cfgRdata),
    .reqValid (reqValid),
    .reqAddr  (reqAddr),
    .rspValid (rspValid),
    .rspAddr  (rspAddr),
    .rspMiss  (rspMiss)
  );

endmodule

// File: rtl/remap_chk.sv
module remap_chk #(
  parameter int NUM_REGIONS = 16,
  parameter int LOCAL_W     = 32,
  parameter int SYS_W       = 48,
  parameter int CFG_AW      = 9,
  parameter bit PASS_THRU   = 1'b1
) (
  input logic               clk,
  input logic               rstN,
  input logic [CFG_AW-1:0]  cfgAddr,
  input logic [LOCAL_W-1:0] cfgRdata,
  input logic               reqValid,
  input logic               rspValid,
  input logic [SYS_W-1:0]   rspAddr,
  input logic               rspMiss
);

  localparam int HI_W  = SYS_W - LOCAL_W;
  localparam int LOW   = 'h20;
  localparam int HIGH  = 'h20 + 'h10 * NUM_REGIONS;

  logic inMap;
  assign inMap = (int'(cfgAddr) >= LOW) && (int'(cfgAddr) < HIGH) &&
                 (cfgAddr[1:0] == 2'b00);

  // R9: response valid follows request valid by one edge
  p_valid_rise_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  p_valid_fall_r9: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R8: miss only accompanies a valid response and carries a zero address
  p_miss_needs_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspMiss |-> rspValid);
  p_miss_zero_addr_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspMiss |-> (rspAddr == '0));

  // R7: pass-through build never flags a miss
  if (PASS_THRU) begin : g_pass_chk
    p_no_miss_r7: assert property (@(posedge clk) disable iff (!rstN)
      rspValid |-> !rspMiss);
  end

  // R3: offsets outside the region blocks read zero
  p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    !inMap |-> (cfgRdata == '0));

  // R4: control word reserved bits read zero
  p_ctrl_reserved_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inMap && cfgAddr[3:2] == 2'd0) |-> (cfgRdata[30:6] == '0));

  // R1: high base word keeps only its low system bits
  p_outhi_upper_r1: assert property (@(posedge clk) disable iff (!rstN)
    (inMap && cfgAddr[3:2] == 2'd3) |-> (cfgRdata[LOCAL_W-1:HI_W] == '0));

endmodule

bind addr_remap_unit remap_chk #(
  .NUM_REGIONS (NUM_REGIONS),
  .LOCAL_W     (LOCAL_W),
  .SYS_W       (SYS_W),
  .CFG_AW      (CFG_AW),
  .PASS_THRU   (PASS_THRU)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgAddr  (cfgAddr),
  .cfgRdata (cfgRdata),
  .reqValid (reqValid),
  .rspValid (rspValid),
  .rspAddr  (rspAddr),
  .rspMiss  (rspMiss)
);

// File: tb/sim_addr_remap_unit.sv
`timescale 1ns/1ps
module sim_addr_remap_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [8:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;

  logic [31:0] rd0, rd1;
  logic        v0, v1, m0, m1;
  logic [47:0] a0, a1;

  int vectors = 0;
  int errors  = 0;

  always #5 clk = ~clk;

  addr_remap_unit #(.PASS_THRU(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(rd0), .reqValid(reqValid),
    .reqAddr(reqAddr), .rspValid(v0), .rspAddr(a0), .rspMiss(m0)
  );

  addr_remap_unit #(.PASS_THRU(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(rd1), .reqValid(reqValid),
    .reqAddr(reqAddr), .rspValid(v1), .rspAddr(a1), .rspMiss(m1)
  );

  task automatic check(input string tag, input logic [47:0] got, input logic [47:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cfgWrite(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic cfgCheck(input string tag, input logic [8:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfgAddr = a;
    #1;
    check({tag, " rd pass"}, 48'(rd0), 48'(exp));
    check({tag, " rd miss"}, 48'(rd1), 48'(exp));
  endtask

  // exp0: pass-through build; exp1/miss1: miss-flag build
  task automatic reqCheck(input string tag, input logic [31:0] addr,
                          input logic [47:0] exp0, input logic [47:0] exp1,
                          input logic miss1);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr;
    @(negedge clk);
    reqValid = 1'b0;
    check({tag, " R9 valid pass"}, 48'(v0), 48'd1);
    check({tag, " R9 valid miss"}, 48'(v1), 48'd1);
    check({tag, " addr pass"}, a0, exp0);
    check({tag, " R7 flag pass"}, 48'(m0), 48'd0);
    check({tag, " addr miss"}, a1, exp1);
    check({tag, " R8 flag miss"}, 48'(m1), 48'(miss1));
    @(negedge clk);
    check({tag, " R9 valid drop"}, 48'(v0 | v1), 48'd0);
  endtask

  task automatic t_reset;
    cfgCheck("R2 ctrl0", 9'h020, 32'h0);
    cfgCheck("R2 outlo5", 9'h078, 32'h0);
    cfgCheck("R2 inbase15", 9'h114, 32'h0);
    reqCheck("R2 R7 R8 nothing enabled", 32'h6000_1234,
             48'h0000_6000_1234, 48'h0, 1'b1);
  endtask

  task automatic t_basic;
    cfgWrite(9'h020, 32'h8000_001D);
    cfgWrite(9'h024, 32'h6000_0000);
    cfgWrite(9'h028, 32'h4000_0000);
    cfgWrite(9'h02C, 32'h0);
    reqCheck("R5 512MB low", 32'h6000_1234, 48'h4000_1234, 48'h4000_1234, 1'b0);
    reqCheck("R5 512MB top", 32'h7FFF_FFFC, 48'h5FFF_FFFC, 48'h5FFF_FFFC, 1'b0);
    reqCheck("R7 R8 past window", 32'h8000_0000, 48'h8000_0000, 48'h0, 1'b1);
  endtask

  task automatic t_readback;
    cfgCheck("R1 R4 ctrl0", 9'h020, 32'h8000_001D);
    cfgWrite(9'h050, 32'hFFFF_FFDD);
    cfgCheck("R4 reserved ctrl3", 9'h050, 32'h8000_001D);
    cfgWrite(9'h05C, 32'hABCD_1234);
    cfgCheck("R1 outhi3", 9'h05C, 32'h0000_1234);
    cfgWrite(9'h114, 32'hCAFE_F00D);
    cfgCheck("R1 R3 inbase15", 9'h114, 32'hCAFE_F00D);
    cfgWrite(9'h098, 32'h1357_2468);
    cfgCheck("R3 outlo7", 9'h098, 32'h1357_2468);
    cfgWrite(9'h010, 32'hFFFF_FFFF);
    cfgCheck("R3 below map", 9'h010, 32'h0);
    cfgCheck("R3 unaligned", 9'h022, 32'h0);
    cfgCheck("R3 above map", 9'h120, 32'h0);
    cfgCheck("R3 ctrl0 untouched", 9'h020, 32'h8000_001D);
    cfgWrite(9'h050, 32'h0);
    cfgCheck("R11 ctrl3 cleared", 9'h050, 32'h0);
    reqCheck("R11 region3 off", 32'h0000_0100, 48'h0000_0100, 48'h0, 1'b1);
  endtask

  task automatic t_wide;
    cfgWrite(9'h030, 32'h8000_001C);
    cfgWrite(9'h034, 32'h9000_1234);
    cfgWrite(9'h038, 32'h8000_0FFF);
    cfgWrite(9'h03C, 32'h0000_0012);
    reqCheck("R5 48bit base low bits ignored", 32'h9ABC_DEF0,
             48'h0012_8ABC_DEF0, 48'h0012_8ABC_DEF0, 1'b0);
    reqCheck("R7 R8 beyond 256MB", 32'hA000_0000, 48'h0000_A000_0000, 48'h0, 1'b1);
  endtask

  task automatic t_priority;
    cfgWrite(9'h040, 32'h8000_001E);
    cfgWrite(9'h044, 32'h8000_0000);
    cfgWrite(9'h048, 32'h0);
    cfgWrite(9'h04C, 32'h0000_0001);
    reqCheck("R6 lower region wins", 32'h9ABC_DEF0,
             48'h0012_8ABC_DEF0, 48'h0012_8ABC_DEF0, 1'b0);
    reqCheck("R5 region2 only", 32'hA000_0010,
             48'h0001_2000_0010, 48'h0001_2000_0010, 1'b0);
    cfgWrite(9'h030, 32'h0);
    reqCheck("R11 region1 off falls to 2", 32'h9ABC_DEF0,
             48'h0001_1ABC_DEF0, 48'h0001_1ABC_DEF0, 1'b0);
  endtask

  task automatic t_fullspace;
    cfgWrite(9'h060, 32'h8000_003F);
    cfgWrite(9'h064, 32'h1234_5678);
    cfgWrite(9'h068, 32'hFFFF_FFFF);
    cfgWrite(9'h06C, 32'h0000_00FF);
    cfgCheck("R4 ctrl4 code 63", 9'h060, 32'h8000_003F);
    reqCheck("R4 clamp full space", 32'h0000_0010,
             48'h00FF_0000_0010, 48'h00FF_0000_0010, 1'b0);
    reqCheck("R6 region0 over region4", 32'h6000_0004,
             48'h4000_0004, 48'h4000_0004, 1'b0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 9'h028; cfgWdata = 32'h2000_0000;
    reqValid = 1'b1; reqAddr = 32'h6000_0010;
    @(negedge clk);
    cfgWe = 1'b0;
    check("R10 old setting same cycle", a0, 48'h4000_0010);
    check("R10 old setting same cycle miss build", a1, 48'h4000_0010);
    @(negedge clk);
    reqValid = 1'b0;
    check("R10 new setting next cycle", a0, 48'h2000_0010);
    check("R10 new setting next cycle miss build", a1, 48'h2000_0010);
    check("R9 valid held", 48'(v0 & v1), 48'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R2 rspValid reset", 48'(v0 | v1), 48'd0);
    check("R2 rspMiss reset", 48'(m0 | m1), 48'd0);
    rstN = 1'b1;
    t_reset();
    t_basic();
    t_readback();
    t_wide();
    t_priority();
    t_fullspace();
    t_same_cycle();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule